// File: doc/BRIEF.md
# Serial Boot Handshake Sequencer

This block sits on the host side of a serial boot link. It controls a 16-bit SPI master frame engine and brings a slave boot target from power-up to a running boot. The engine itself is outside the block. It has three stages. First, the start-word stage sends a 16-bit start word over and over until the target returns its own reply word. Second, the ping stage checks that the link is sound by exchanging a ping opcode and then a run of echoed count values. Third, the command stage takes words from a valid/ready stream. An opcode is resent until the target acknowledges it, and then the opcode's arguments go out without any check.

Every value after the start stage is 32 bits wide. Each one travels as two 16-bit frames, lower half first, and each reply is rebuilt in the same order. The frame engine is assumed to return, in the receive word of a frame, the target's answer to that same frame. Between frames the block leaves an idle gap. The gap length comes from one of two inputs, so software can switch to the shorter one once the target's clock is running fast. A retry limit caps the number of failed attempts allowed in a stage that retries. When the limit is reached, the block stops and raises an error.

Top module: `boot_sync_seq`

## Requirements
- R1: After reset, frm_req, cmd_ready, boot_done and boot_err are all low. A one-cycle pulse on boot_go starts a run from the idle, done or error state. A boot_go pulse that arrives while a run is in progress has no effect.
- R2: The first stage sends frames that carry 0x5853. It keeps sending them until a frame's frm_rx equals 0x5253. The stage then ends, and every later value is 32 bits.
- R3: Each 32-bit value goes out as two frames. Bits 15:0 go first and bits 31:16 go second. The reply is rebuilt with the first frame's frm_rx as bits 15:0 and the second frame's frm_rx as bits 31:16.
- R4: After the start stage, the block sends the ping opcode 0x5853590B and expects 0x5253590B back. On any other reply it resends the ping opcode.
- R5: After the ping is acknowledged, the block sends the count N. N is taken from ping_n at the boot_go pulse. Once N is echoed, the block sends each value from 1 up to N and expects each one echoed back. N = 0 skips the value run. Any echo mismatch in this stage raises boot_err at once.
- R6: A stream word with cmd_is_op = 1 is an opcode. Its expected acknowledgement is the same word with bits 31:24 replaced by 0x52. The block resends the opcode until that acknowledgement arrives.
- R7: A stream word with cmd_is_op = 0 is an argument. It is sent once, in stream order, and its reply is not checked.
- R8: In the start, ping-opcode and opcode stages, a failed attempt increments a per-stage counter. When the count of consecutive failures reaches retry_limit, boot_err rises and no further frame is requested.
- R9: After each frame, frm_req stays low for exactly G+1 cycles before the next frame, provided the next frame does not wait on the stream. G is gap_short when gap_use_short was high in the cycle the frame ended, and gap_long otherwise.
- R10: cmd_ready is high only while the block waits for the next stream word, and never while a frame is requested. A word with cmd_last = 1 ends the run with boot_done. For an argument this happens after its frames; for an opcode it happens after its acknowledgement.
- R11: boot_done and boot_err are never high together. Each one holds until the next accepted boot_go.
- R12: While frm_req is high and frm_done has not arrived, frm_req and frm_tx stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_go | input | 1 | Pulse that starts a boot run |
| ping_n | input | 32 | Echo count N, sampled at boot_go |
| gap_long | input | GAP_W | Idle cycles between frames, slow setting |
| gap_short | input | GAP_W | Idle cycles between frames, fast setting |
| gap_use_short | input | 1 | Selects gap_short instead of gap_long |
| retry_limit | input | RETRY_W | Consecutive failures allowed per retrying stage |
| cmd_valid | input | 1 | Stream word present |
| cmd_ready | output | 1 | Stream word accepted this cycle if valid |
| cmd_word | input | 32 | Opcode or argument value |
| cmd_is_op | input | 1 | 1 = opcode, 0 = argument |
| cmd_last | input | 1 | Final word of the boot stream |
| frm_req | output | 1 | Frame request to the SPI master |
| frm_tx | output | 16 | Frame transmit data |
| frm_done | input | 1 | One-cycle pulse at the end of a frame |
| frm_rx | input | 16 | Frame receive data, valid with frm_done |
| boot_done | output | 1 | Boot stream finished |
| boot_err | output | 1 | Run halted on error |

## Verification
The bench builds the block with its default parameters: lower-half-first splitting, a 16-bit gap field and an 8-bit retry field. The retry limit and the gap lengths are inputs, so small values are applied at run time. With a limit of 4, the retry cap is reached within a few frames. Gaps of 5 and 1 cycles allow the idle time to be counted exactly at both settings. A target model in the bench holds back its start-word reply, refuses each opcode once and can corrupt an echo. This exercises every retry path and error path of the three stages.

// File: rtl/bs_pkg.sv
package bs_pkg;

   localparam logic [15:0] SYNC_TX_WORD = 16'h5853;
   localparam logic [15:0] SYNC_RX_WORD = 16'h5253;
   localparam logic [31:0] PING_OPCODE  = 32'h5853590B;
   localparam logic [31:0] PING_ACK     = 32'h5253590B;
   localparam logic [7:0]  ACK_TOP_BYTE = 8'h52;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_SYNC,
      PH_PING,
      PH_CNT_N,
      PH_CNT_SEQ,
      PH_FETCH,
      PH_OPC,
      PH_ARG,
      PH_DONE,
      PH_FAIL
   } phase_t;

   typedef enum logic [1:0] {
      SUB_XFER,
      SUB_GAP,
      SUB_WAIT
   } sub_t;

endpackage

// File: rtl/bs_gap_timer.sv
module bs_gap_timer #(
   parameter int GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             use_short,
   input  logic [GAP_W-1:0] gap_long,
   input  logic [GAP_W-1:0] gap_short,
   output logic             expire
);

   generate
      if (GAP_W < 1) begin : g_bad_gap_w
         $error("bs_gap_timer: GAP_W must be at least 1");
      end
   endgenerate

   logic [GAP_W-1:0] chosen;
   logic [GAP_W-1:0] cnt_q;
   logic             run_q;

   assign chosen = use_short ? gap_short : gap_long;
   assign expire = run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         cnt_q <= chosen;
      end else if (run_q) begin
         if (cnt_q == '0) begin
            run_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R9: a nonzero gap never ends in the cycle right after it is loaded
   assert_gap_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (chosen != '0)) |=> !expire);

endmodule

// File: rtl/bs_retry_ctr.sv
module bs_retry_ctr #(
   parameter int RETRY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               fail,
   input  logic [RETRY_W-1:0] limit,
   output logic               at_limit
);

   generate
      if (RETRY_W < 1) begin : g_bad_retry_w
         $error("bs_retry_ctr: RETRY_W must be at least 1");
      end
   endgenerate

   localparam int CNT_W = RETRY_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc  = cnt_q + 1'b1;
   assign at_limit = (cnt_inc >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (fail && !cnt_q[CNT_W-1]) begin
         cnt_q <= cnt_inc;
      end
   end

   // R8: the counter starts a stage from zero
   assert_retry_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (limit > 1)) |=> !at_limit);

endmodule

// File: rtl/bs_half_split.sv
module bs_half_split #(
   parameter int FRAME_W   = 16,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*FRAME_W-1:0] word,
   input  logic                 second,
   input  logic [FRAME_W-1:0]   rx,
   input  logic                 cap_first,
   output logic [FRAME_W-1:0]   tx,
   output logic [2*FRAME_W-1:0] reply
);

   logic [FRAME_W-1:0] first_q;
   logic [FRAME_W-1:0] word_lo;
   logic [FRAME_W-1:0] word_hi;

   assign word_lo = word[FRAME_W-1:0];
   assign word_hi = word[2*FRAME_W-1:FRAME_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
      end else if (cap_first) begin
         first_q <= rx;
      end
   end

   generate
      if (LOW_FIRST) begin : g_low_first
         assign tx    = second ? word_hi : word_lo;
         assign reply = {rx, first_q};
      end else begin : g_high_first
         assign tx    = second ? word_lo : word_hi;
         assign reply = {first_q, rx};
      end
   endgenerate

endmodule

// File: rtl/boot_sync_seq.sv
module boot_sync_seq
   import bs_pkg::*;
#(
   parameter int FRAME_W   = 16,
   parameter int GAP_W     = 16,
   parameter int RETRY_W   = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 boot_go,
   input  logic [2*FRAME_W-1:0] ping_n,
   input  logic [GAP_W-1:0]     gap_long,
   input  logic [GAP_W-1:0]     gap_short,
   input  logic                 gap_use_short,
   input  logic [RETRY_W-1:0]   retry_limit,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [2*FRAME_W-1:0] cmd_word,
   input  logic                 cmd_is_op,
   input  logic                 cmd_last,
   output logic                 frm_req,
   output logic [FRAME_W-1:0]   frm_tx,
   input  logic                 frm_done,
   input  logic [FRAME_W-1:0]   frm_rx,
   output logic                 boot_done,
   output logic                 boot_err
);

   localparam int WORD_W = 2 * FRAME_W;

   generate
      if (FRAME_W != 16) begin : g_bad_frame_w
         $error("boot_sync_seq: the link protocol fixes FRAME_W at 16");
      end
   endgenerate

   phase_t            phase_q, phase_d;
   sub_t              sub_q, sub_d;
   logic [WORD_W-1:0] word_q, word_d;
   logic [WORD_W-1:0] n_q;
   logic              half_q, half_d;
   logic              last_q, last_d;

   logic              start_ev;
   logic              fetch_ev;
   logic              frame_end;
   logic              gap_load;
   logic              gap_expire;
   logic              retry_fail;
   logic              retry_clr;
   logic              retry_at_limit;
   logic              echo_bad;
   logic [FRAME_W-1:0] split_tx;
   logic [WORD_W-1:0] reply;
   logic [WORD_W-1:0] op_ack;

   assign start_ev  = boot_go && ((phase_q == PH_IDLE) || (phase_q == PH_DONE) ||
                                  (phase_q == PH_FAIL));
   assign frm_req   = (sub_q == SUB_XFER);
   assign cmd_ready = (phase_q == PH_FETCH) && (sub_q == SUB_WAIT);
   assign fetch_ev  = cmd_ready && cmd_valid;
   assign frame_end = frm_req && frm_done;
   assign frm_tx    = (phase_q == PH_SYNC) ? SYNC_TX_WORD : split_tx;
   assign boot_done = (phase_q == PH_DONE);
   assign boot_err  = (phase_q == PH_FAIL);
   assign op_ack    = {ACK_TOP_BYTE, word_q[WORD_W-9:0]};

   bs_half_split #(
      .FRAME_W   (FRAME_W),
      .LOW_FIRST (LOW_FIRST)
   ) split_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .word      (word_q),
      .second    (half_q),
      .rx        (frm_rx),
      .cap_first (frame_end && !half_q && (phase_q != PH_SYNC)),
      .tx        (split_tx),
      .reply     (reply)
   );

   bs_gap_timer #(
      .GAP_W (GAP_W)
   ) gap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (gap_load),
      .use_short (gap_use_short),
      .gap_long  (gap_long),
      .gap_short (gap_short),
      .expire    (gap_expire)
   );

   bs_retry_ctr #(
      .RETRY_W (RETRY_W)
   ) retry_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (retry_clr),
      .fail     (retry_fail),
      .limit    (retry_limit),
      .at_limit (retry_at_limit)
   );

   // Decision logic: runs at the end of each frame, on gap expiry and on stream accept
   always_comb begin
      phase_d    = phase_q;
      sub_d      = sub_q;
      word_d     = word_q;
      half_d     = half_q;
      last_d     = last_q;
      retry_fail = 1'b0;
      retry_clr  = 1'b0;
      gap_load   = 1'b0;
      echo_bad   = 1'b0;

      if (start_ev) begin
         phase_d   = PH_SYNC;
         sub_d     = SUB_XFER;
         half_d    = 1'b0;
         retry_clr = 1'b1;
      end else if (frame_end) begin
         if (phase_q == PH_SYNC) begin
            if (frm_rx == SYNC_RX_WORD) begin
               phase_d   = PH_PING;
               word_d    = PING_OPCODE;
               half_d    = 1'b0;
               retry_clr = 1'b1;
            end else begin
               retry_fail = 1'b1;
            end
         end else if (!half_q) begin
            half_d = 1'b1;
         end else begin
            half_d = 1'b0;
            unique case (phase_q)
               PH_PING: begin
                  if (reply == PING_ACK) begin
                     phase_d   = PH_CNT_N;
                     word_d    = n_q;
                     retry_clr = 1'b1;
                  end else begin
                     retry_fail = 1'b1;
                  end
               end
               PH_CNT_N: begin
                  if (reply != word_q) begin
                     echo_bad = 1'b1;
                  end else if (word_q == '0) begin
                     phase_d = PH_FETCH;
                  end else begin
                     phase_d = PH_CNT_SEQ;
                     word_d  = {{(WORD_W-1){1'b0}}, 1'b1};
                  end
               end
               PH_CNT_SEQ: begin
                  if (reply != word_q) begin
                     echo_bad = 1'b1;
                  end else if (word_q == n_q) begin
                     phase_d = PH_FETCH;
                  end else begin
                     word_d = word_q + 1'b1;
                  end
               end
               PH_OPC: begin
                  if (reply == op_ack) begin
                     phase_d   = last_q ? PH_DONE : PH_FETCH;
                     retry_clr = 1'b1;
                  end else begin
                     retry_fail = 1'b1;
                  end
               end
               PH_ARG: begin
                  phase_d = last_q ? PH_DONE : PH_FETCH;
               end
               default: begin
                  phase_d = phase_q;
               end
            endcase
         end

         if (echo_bad || (retry_fail && retry_at_limit)) begin
            phase_d = PH_FAIL;
         end

         if ((phase_d == PH_DONE) || (phase_d == PH_FAIL)) begin
            sub_d = SUB_WAIT;
         end else begin
            sub_d    = SUB_GAP;
            gap_load = 1'b1;
         end
      end else if ((sub_q == SUB_GAP) && gap_expire) begin
         sub_d = (phase_q == PH_FETCH) ? SUB_WAIT : SUB_XFER;
      end else if (fetch_ev) begin
         word_d    = cmd_word;
         last_d    = cmd_last;
         phase_d   = cmd_is_op ? PH_OPC : PH_ARG;
         half_d    = 1'b0;
         sub_d     = SUB_XFER;
         retry_clr = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sub_q   <= SUB_WAIT;
         word_q  <= '0;
         n_q     <= '0;
         half_q  <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         sub_q   <= sub_d;
         word_q  <= word_d;
         half_q  <= half_d;
         last_q  <= last_d;
         if (start_ev) begin
            n_q <= ping_n;
         end
      end
   end

   // R12: a requested frame keeps its data until the engine finishes it
   assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_req && !frm_done) |=> (frm_req && $stable(frm_tx)));

   // R9: a finished frame is always followed by at least one idle cycle
   assert_gap_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_req && frm_done) |=> !frm_req);

   // R11: the two status flags exclude each other
   assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(boot_done && boot_err));

   // R11: the error flag persists until a new start
   assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_err && !boot_go) |=> boot_err);

   // R8: a halted run requests nothing
   assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      boot_err |-> (!frm_req && !cmd_ready));

   // R10: the stream is never accepted during a frame
   assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !frm_req);

endmodule

// File: tb/boot_sync_seq_tb_top.sv
module boot_sync_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;

   logic        clk;
   logic        rst_n;
   logic        boot_go;
   logic [31:0] ping_n;
   logic [15:0] gap_long;
   logic [15:0] gap_short;
   logic        gap_use_short;
   logic [7:0]  retry_limit;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [31:0] cmd_word;
   logic        cmd_is_op;
   logic        cmd_last;
   logic        frm_req;
   logic [15:0] frm_tx;
   logic        frm_done;
   logic [15:0] frm_rx;
   logic        boot_done;
   logic        boot_err;

   boot_sync_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .boot_go       (boot_go),
      .ping_n        (ping_n),
      .gap_long      (gap_long),
      .gap_short     (gap_short),
      .gap_use_short (gap_use_short),
      .retry_limit   (retry_limit),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_word      (cmd_word),
      .cmd_is_op     (cmd_is_op),
      .cmd_last      (cmd_last),
      .frm_req       (frm_req),
      .frm_tx        (frm_tx),
      .frm_done      (frm_done),
      .frm_rx        (frm_rx),
      .boot_done     (boot_done),
      .boot_err      (boot_err)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // target model state
   int          sws_busy, sws_seen, busy_each, busy_left;
   bit          synced, half_t, corrupt;
   logic [15:0] flog [0:255];
   int          fcnt;
   int          gaps [0:255];
   int          lowrun;
   bit          req_prev;
   logic [15:0] tx_prev;
   int          tx_bad;

   // expected frames
   logic [15:0] ef [0:255];
   int          en;

   // command stream source
   logic [31:0] cw [0:15];
   bit          cop [0:15];
   bit          clast [0:15];
   int          cmd_n, cmd_i;

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic respond(input logic [15:0] tx);
      if (fcnt < 256) flog[fcnt] = tx;
      fcnt++;
      if (!synced) begin
         if (sws_seen >= sws_busy && tx == 16'h5853) begin
            frm_rx = 16'h5253;
            synced = 1;
            half_t = 0;
         end else begin
            frm_rx = 16'h0000;
         end
         sws_seen++;
      end else if (!half_t) begin
         frm_rx = tx;
         half_t = 1;
      end else begin
         half_t = 0;
         if (tx == 16'h5853) begin
            if (busy_left > 0) begin
               frm_rx = 16'h0000;
               busy_left--;
            end else begin
               frm_rx = 16'h5253;
               busy_left = busy_each;
            end
         end else begin
            frm_rx = corrupt ? (tx ^ 16'h0001) : tx;
         end
      end
   endtask

   // frame engine and target model
   initial begin
      frm_done = 1'b0;
      frm_rx   = '0;
      forever begin
         @(negedge clk);
         if (frm_done) begin
            frm_done = 1'b0;
         end else if (frm_req) begin
            repeat (LAT - 1) @(negedge clk);
            respond(frm_tx);
            frm_done = 1'b1;
         end
      end
   end

   // idle-gap and transmit-stability monitor
   initial begin
      lowrun = 0; req_prev = 0; tx_prev = '0; tx_bad = 0;
      forever begin
         @(negedge clk);
         if (frm_req && !req_prev && fcnt < 256) gaps[fcnt] = lowrun;
         if (frm_req && req_prev && frm_tx !== tx_prev) tx_bad++;
         if (frm_req) lowrun = 0;
         else lowrun++;
         req_prev = frm_req;
         tx_prev  = frm_tx;
      end
   end

   // stream handshake
   initial begin
      forever begin
         @(posedge clk);
         if (cmd_valid && cmd_ready) cmd_i++;
      end
   end

   initial begin
      cmd_valid = 0; cmd_word = '0; cmd_is_op = 0; cmd_last = 0;
      forever begin
         @(negedge clk);
         cmd_valid = (cmd_i < cmd_n);
         if (cmd_i < cmd_n) begin
            cmd_word  = cw[cmd_i];
            cmd_is_op = cop[cmd_i];
            cmd_last  = clast[cmd_i];
         end
      end
   end

   task automatic model_reset(input int sb, input int be, input bit cor);
      sws_busy = sb; sws_seen = 0; busy_each = be; busy_left = be;
      synced = 0; half_t = 0; corrupt = cor; fcnt = 0; en = 0;
      cmd_n = 0; cmd_i = 0;
      for (int i = 0; i < 256; i++) gaps[i] = -1;
   endtask

   task automatic push(input logic [15:0] f);
      ef[en] = f;
      en++;
   endtask

   task automatic push_word(input logic [31:0] w);
      push(w[15:0]);
      push(w[31:16]);
   endtask

   task automatic add_cmd(input logic [31:0] w, input bit op, input bit lst);
      cw[cmd_n] = w; cop[cmd_n] = op; clast[cmd_n] = lst;
      cmd_n++;
   endtask

   task automatic go_pulse();
      @(negedge clk); boot_go = 1'b1;
      @(negedge clk); boot_go = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 4000 && !(boot_done || boot_err); i++) @(negedge clk);
   endtask

   task automatic cmp_frames(input string tag);
      int bad;
      bad = -1;
      for (int i = 0; i < en; i++) begin
         if (bad < 0 && flog[i] !== ef[i]) bad = i;
      end
      chk(fcnt == en, tag, "frame count", fcnt, en);
      chk(bad < 0, tag, "frame sequence", (bad < 0) ? 32'd0 : {16'd0, flog[bad]},
          (bad < 0) ? 32'd0 : {16'd0, ef[bad]});
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!frm_req && !cmd_ready && !boot_done && !boot_err, "R1", "reset outputs",
          {frm_req, cmd_ready, boot_done, boot_err}, 0);
   endtask

   // full boot: delayed start word, one refusal per opcode, N = 2
   task automatic t_full_boot();
      model_reset(3, 1, 0);
      ping_n = 2;
      add_cmd(32'h58535901, 1, 0);
      add_cmd(32'h11112222, 0, 0);
      add_cmd(32'h33334444, 0, 0);
      add_cmd(32'h58535907, 1, 1);
      repeat (4) push(16'h5853);
      push_word(32'h5853590B); push_word(32'h5853590B);
      push_word(32'd2); push_word(32'd1); push_word(32'd2);
      push_word(32'h58535901); push_word(32'h58535901);
      push_word(32'h11112222); push_word(32'h33334444);
      push_word(32'h58535907); push_word(32'h58535907);
      go_pulse();
      wait_end();
      chk(boot_done == 1'b1 && boot_err == 1'b0, "R10", "done after last opcode ack",
          {boot_done, boot_err}, 32'h2);
      cmp_frames("R2 R3 R4 R5 R6 R7");
      chk(cmd_i == cmd_n, "R10", "stream words consumed", cmd_i, cmd_n);
      chk(tx_bad == 0, "R12", "tx changed mid-frame", tx_bad, 0);
      repeat (20) @(negedge clk);
      chk(boot_done == 1'b1, "R11", "done held", boot_done, 1);
   endtask

   // N = 0 skips the value run; argument marked last ends the run
   task automatic t_count_zero();
      model_reset(0, 0, 0);
      ping_n = 0;
      add_cmd(32'hAAAA5555, 0, 1);
      push(16'h5853);
      push_word(32'h5853590B);
      push_word(32'd0);
      push_word(32'hAAAA5555);
      go_pulse();
      chk(boot_done == 1'b0, "R11", "done cleared by new start", boot_done, 0);
      wait_end();
      chk(boot_done == 1'b1, "R7", "done after last argument", boot_done, 1);
      cmp_frames("R5 R7");
   endtask

   // retry limit on the start word; boot_go mid-run ignored
   task automatic t_retry_limit();
      model_reset(1000, 0, 0);
      retry_limit = 8'd4;
      go_pulse();
      for (int i = 0; i < 400 && fcnt < 2; i++) @(negedge clk);
      go_pulse();
      wait_end();
      repeat (50) @(negedge clk);
      chk(boot_err == 1'b1, "R8", "error after limit", boot_err, 1);
      chk(fcnt == 4, "R1", "start frames with mid-run boot_go", fcnt, 4);
      chk(!frm_req, "R8", "no request after error", frm_req, 0);
      chk(boot_err == 1'b1 && boot_done == 1'b0, "R11", "error held", {boot_done, boot_err}, 1);
      retry_limit = 8'd8;
   endtask

   // corrupted echo of N
   task automatic t_echo_bad();
      model_reset(0, 0, 1);
      ping_n = 3;
      push(16'h5853);
      push_word(32'h5853590B);
      push_word(32'd3);
      go_pulse();
      chk(boot_err == 1'b0, "R11", "error cleared by new start", boot_err, 0);
      wait_end();
      repeat (20) @(negedge clk);
      chk(boot_err == 1'b1, "R5", "echo mismatch raises error", boot_err, 1);
      cmp_frames("R5");
   endtask

   // idle gap length for both settings
   task automatic t_gap(input bit use_short, input int exp_gap);
      model_reset(2, 0, 0);
      ping_n = 0;
      gap_long = 16'd5;
      gap_short = 16'd1;
      gap_use_short = use_short;
      add_cmd(32'h01020304, 0, 1);
      go_pulse();
      wait_end();
      chk(boot_done == 1'b1, "R9", "run completes", boot_done, 1);
      chk(gaps[1] == exp_gap, "R9", "idle cycles before frame 1", gaps[1], exp_gap);
      chk(gaps[2] == exp_gap, "R9", "idle cycles before frame 2", gaps[2], exp_gap);
      gap_long = 16'd2;
      gap_use_short = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; boot_go = 1'b0; ping_n = 2;
      gap_long = 16'd2; gap_short = 16'd1; gap_use_short = 1'b0;
      retry_limit = 8'd8;
      model_reset(0, 0, 0);
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_full_boot();
      t_count_zero();
      t_retry_limit();
      t_echo_bad();
      t_gap(1'b0, 6);
      t_gap(1'b1, 2);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule